// File: doc/BRIEF.md
# Hardware-Triggered Command Frame Generator

This block turns rising edges on a set of external trigger lines into command-frame requests for a serial link transmitter. Each trigger line is brought into the clock domain through a flip-flop synchroniser. A rising edge on a synchronised line sets a pending bit for that trigger. While any pending bit is set, the block offers a frame request to the transmitter. The request names a fixed pipe and carries a command code equal to the trigger index plus one.

When several triggers are pending, the lowest index is offered first. The transmitter takes a frame through a valid/ready handshake, and that acceptance clears the pending bit it served. If an edge arrives while its bit is already pending, it is merged into that bit. Software can drop pending requests by writing a mask of ones to the clear port. The pending vector is visible at the outputs at all times.

Top module: `trig_cmd_gen`

## Requirements
- R1: While reset is held and on the first cycle after it, `pend_o` is all zero and `req_valid_o` is 0.
- R2: A rising edge on `trig_i[i]` sets `pend_o[i]`. The bit is 0 after the second rising clock edge counted from the first edge that samples the line high, and it is 1 after the third.
- R3: When any pending bit is set, `req_valid_o` is 1. In that case `req_pipe_o` is 0 (binary 00) and `req_cmd_o` is the binary value of the served trigger index plus one, so trigger 0 gives 1 and trigger 3 gives 4. When no bit is pending, `req_valid_o` is 0.
- R4: When several bits are pending, the request serves the lowest-numbered pending trigger.
- R5: A clock edge where `req_valid_o` and `req_ready_i` are both 1 clears only the pending bit of the trigger being served. All other pending bits keep their value.
- R6: An edge on a trigger whose bit is already pending is merged into that bit. After one accepted frame, that trigger has nothing left to send.
- R7: A clock edge with `clr_we_i` at 1 clears every pending bit whose `clr_mask_i` bit is 1. Bits whose mask bit is 0 are left unchanged.
- R8: A synchronised edge on a trigger in the same cycle as a software clear or a transmitter acceptance of that same bit leaves the bit set.
- R9: A trigger line that stays high, or that falls, sets no pending bit. `req_ready_i` while `req_valid_o` is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trig_i | input | NUM_TRIG | Asynchronous trigger lines |
| clr_we_i | input | 1 | Software clear strobe |
| clr_mask_i | input | NUM_TRIG | Bits to clear, one per trigger |
| req_ready_i | input | 1 | Transmitter is ready to take the offered frame |
| req_valid_o | output | 1 | A command frame is offered |
| req_pipe_o | output | PIPE_W | Pipe number of the offered frame |
| req_cmd_o | output | CMD_W | Command code of the offered frame |
| pend_o | output | NUM_TRIG | Pending bit per trigger |

## Verification
A trigger level change shows up in `pend_o` and `req_valid_o` exactly three clock edges after the first edge that samples it: two synchroniser stages, then the pending register. The request fields follow the pending vector in the same cycle with no extra delay. A handshake or software clear takes effect at the next edge. The bench drives every input on the falling clock edge and counts rising edges one by one. It samples one edge before and one edge at each due point, so a late or an early result both fail. The edge-wins cases place the clear or ready strobe in the cycle before the third edge, which is when the synchronised edge meets it.

// File: rtl/trig_cmd_pkg.sv
package trig_cmd_pkg;

   // index width for a vector of n lanes (at least one bit)
   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   // bits needed to carry a code from 1 up to n
   function automatic int unsigned code_width(input int unsigned n);
      return $clog2(n + 1);
   endfunction

endpackage

// File: rtl/trig_sync_edge.sv
module trig_sync_edge #(
   parameter int unsigned N      = 4,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] trig_i,
   output logic [N-1:0] rise_o
);

   initial begin
      assert (STAGES >= 2) else $error("trig_sync_edge: STAGES must be at least 2");
      assert (N >= 1)      else $error("trig_sync_edge: N must be at least 1");
   end

   for (genvar g = 0; g < N; g++) begin : g_lane
      logic [STAGES-1:0] chain_q;
      logic              last_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain_q <= '0;
            last_q  <= 1'b0;
         end else begin
            chain_q <= {chain_q[STAGES-2:0], trig_i[g]};
            last_q  <= chain_q[STAGES-1];
         end
      end

      assign rise_o[g] = chain_q[STAGES-1] & ~last_q;
   end

endmodule

// File: rtl/trig_pend.sv
module trig_pend #(
   parameter int unsigned N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] rise_i,
   input  logic         clr_we_i,
   input  logic [N-1:0] clr_mask_i,
   input  logic [N-1:0] take_i,
   output logic [N-1:0] pend_o
);

   logic [N-1:0] pend_q;
   logic [N-1:0] drop;
   logic [N-1:0] pend_d;

   always_comb begin
      drop   = take_i | (clr_we_i ? clr_mask_i : '0);
      // a fresh edge outranks both a clear and an acceptance
      pend_d = (pend_q & ~drop) | rise_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= pend_d;
   end

   assign pend_o = pend_q;

   // R2 / R8: a detected edge always lands in its pending bit
   a_r2_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_i != '0) |=> ((pend_q & $past(rise_i)) == $past(rise_i)));

   // R5: an accepted frame clears its bit unless a new edge arrives with it
   a_r5_take_clears: assert property (@(posedge clk) disable iff (!rst_n)
      ((take_i != '0) && ((take_i & rise_i) == '0)) |=> ((pend_q & $past(take_i)) == '0));

   // R7: software clear drops every masked bit without a competing edge
   a_r7_sw_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we_i && ((clr_mask_i & rise_i) == '0)) |=> ((pend_q & $past(clr_mask_i)) == '0));

   // R9: no pending bit appears without a detected edge
   a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(rise_i)) == '0));

endmodule

// File: rtl/trig_arb.sv
module trig_arb #(
   parameter int unsigned N     = 4,
   parameter int unsigned IDX_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     pend_i,
   output logic             any_o,
   output logic [N-1:0]     grant_o,
   output logic [IDX_W-1:0] idx_o
);

   always_comb begin
      grant_o = '0;
      idx_o   = '0;
      // scan downward so the lowest pending index is the last to win
      for (int i = N - 1; i >= 0; i--) begin
         if (pend_i[i]) begin
            grant_o    = '0;
            grant_o[i] = 1'b1;
            idx_o      = IDX_W'(i);
         end
      end
   end

   assign any_o = |pend_i;

   // R4: exactly one grant, and no pending bit below it
   a_r4_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
      any_o |-> ($onehot(grant_o) && ((pend_i & (grant_o - N'(1))) == '0)));

   a_r4_grant_is_pending: assert property (@(posedge clk) disable iff (!rst_n)
      ((grant_o & ~pend_i) == '0));

endmodule

// File: rtl/trig_cmd_gen.sv
module trig_cmd_gen
   import trig_cmd_pkg::*;
#(
   parameter int unsigned NUM_TRIG    = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned PIPE_W      = 2,
   parameter int unsigned PIPE_ID     = 0,
   parameter int unsigned CMD_W       = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_TRIG-1:0] trig_i,
   input  logic                clr_we_i,
   input  logic [NUM_TRIG-1:0] clr_mask_i,
   input  logic                req_ready_i,
   output logic                req_valid_o,
   output logic [PIPE_W-1:0]   req_pipe_o,
   output logic [CMD_W-1:0]    req_cmd_o,
   output logic [NUM_TRIG-1:0] pend_o
);

   localparam int unsigned IDX_W = idx_width(NUM_TRIG);

   initial begin
      assert (CMD_W >= code_width(NUM_TRIG))
         else $error("trig_cmd_gen: CMD_W too narrow for NUM_TRIG codes");
      assert (PIPE_ID < (1 << PIPE_W))
         else $error("trig_cmd_gen: PIPE_ID does not fit PIPE_W");
   end

   logic [NUM_TRIG-1:0] rise;
   logic [NUM_TRIG-1:0] grant;
   logic [NUM_TRIG-1:0] take;
   logic [IDX_W-1:0]    idx;
   logic                any;

   trig_sync_edge #(.N(NUM_TRIG), .STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .trig_i (trig_i),
      .rise_o (rise)
   );

   trig_pend #(.N(NUM_TRIG)) u_pend (
      .clk        (clk),
      .rst_n      (rst_n),
      .rise_i     (rise),
      .clr_we_i   (clr_we_i),
      .clr_mask_i (clr_mask_i),
      .take_i     (take),
      .pend_o     (pend_o)
   );

   trig_arb #(.N(NUM_TRIG), .IDX_W(IDX_W)) u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .pend_i  (pend_o),
      .any_o   (any),
      .grant_o (grant),
      .idx_o   (idx)
   );

   assign take        = grant & {NUM_TRIG{any & req_ready_i}};
   assign req_valid_o = any;
   assign req_pipe_o  = PIPE_W'(PIPE_ID);
   assign req_cmd_o   = CMD_W'(idx) + CMD_W'(1);

   // R3: the offered code names a trigger that is really pending
   a_r3_cmd_pending: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid_o |-> ((req_cmd_o != '0) &&
                       (((pend_o >> (req_cmd_o - CMD_W'(1))) & NUM_TRIG'(1)) != '0)));

   // R3: code stays within 1..NUM_TRIG
   a_r3_cmd_range: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid_o |-> (req_cmd_o <= CMD_W'(NUM_TRIG)));

endmodule

// File: tb/tb_trig_cmd_gen.sv
module tb_trig_cmd_gen;

   localparam int N = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] trig = '0;
   logic         clr_we = 1'b0;
   logic [N-1:0] clr_mask = '0;
   logic         ready = 1'b0;
   logic         valid;
   logic [1:0]   pipe;
   logic [3:0]   cmd;
   logic [N-1:0] pend;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   always #5 clk = ~clk;

   trig_cmd_gen dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .trig_i      (trig),
      .clr_we_i    (clr_we),
      .clr_mask_i  (clr_mask),
      .req_ready_i (ready),
      .req_valid_o (valid),
      .req_pipe_o  (pipe),
      .req_cmd_o   (cmd),
      .pend_o      (pend)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic flush_low();
      trig = '0;
      tick(3);
   endtask

   task automatic t_reset();
      chk("R1 pend in reset", pend, 0);
      chk("R1 valid in reset", valid, 0);
      rst_n = 1'b1;
      tick(1);
      chk("R1 pend after reset", pend, 0);
      chk("R1 valid after reset", valid, 0);
   endtask

   task automatic t_single();
      trig[2] = 1'b1;
      tick(2);
      chk("R2 not yet set", pend, 0);
      tick(1);
      chk("R2 set on third edge", pend, 4'b0100);
      chk("R3 valid", valid, 1);
      chk("R3 pipe", pipe, 0);
      chk("R3 cmd trig2", cmd, 3);
      ready = 1'b1;
      tick(1);
      ready = 1'b0;
      chk("R5 cleared by accept", pend, 0);
      chk("R3 valid low when idle", valid, 0);
      tick(3);
      chk("R9 held high no retrigger", pend, 0);
      flush_low();
      chk("R9 falling edge no set", pend, 0);
   endtask

   task automatic t_multi();
      trig = 4'b1011;
      tick(3);
      chk("R2 several set", pend, 4'b1011);
      chk("R4 lowest first cmd", cmd, 1);
      ready = 1'b1;
      tick(1);
      chk("R5 only served bit cleared", pend, 4'b1010);
      chk("R4 next lowest cmd", cmd, 2);
      tick(1);
      chk("R5 second accept", pend, 4'b1000);
      chk("R3 cmd trig3", cmd, 4);
      tick(1);
      chk("R5 third accept", pend, 0);
      chk("R3 valid drops", valid, 0);
      ready = 1'b0;
      flush_low();
   endtask

   task automatic t_merge();
      trig[1] = 1'b1;
      tick(3);
      chk("R6 first edge", pend, 4'b0010);
      flush_low();
      trig[1] = 1'b1;
      tick(3);
      chk("R6 merged still one bit", pend, 4'b0010);
      ready = 1'b1;
      tick(1);
      ready = 1'b0;
      chk("R6 one frame drains it", pend, 0);
      chk("R6 valid after one frame", valid, 0);
      flush_low();
   endtask

   task automatic t_clear();
      trig = 4'b0101;
      tick(3);
      chk("R7 setup", pend, 4'b0101);
      clr_we = 1'b1;
      clr_mask = 4'b0001;
      tick(1);
      clr_we = 1'b0;
      clr_mask = '0;
      chk("R7 masked bit cleared", pend, 4'b0100);
      chk("R7 cmd moves on", cmd, 3);
      clr_mask = 4'b0100;
      tick(1);
      chk("R7 mask without strobe ignored", pend, 4'b0100);
      clr_we = 1'b1;
      tick(1);
      clr_we = 1'b0;
      clr_mask = '0;
      chk("R7 cleared all", pend, 0);
      flush_low();
   endtask

   task automatic t_edge_wins();
      trig[1] = 1'b1;
      tick(3);
      flush_low();
      chk("R8 setup pending", pend, 4'b0010);
      trig[1] = 1'b1;
      tick(2);
      clr_we = 1'b1;
      clr_mask = 4'b0010;
      tick(1);
      clr_we = 1'b0;
      clr_mask = '0;
      chk("R8 edge beats clear", pend, 4'b0010);
      flush_low();
      trig[1] = 1'b1;
      tick(2);
      ready = 1'b1;
      tick(1);
      ready = 1'b0;
      chk("R8 edge beats accept", pend, 4'b0010);
      ready = 1'b1;
      tick(1);
      ready = 1'b0;
      chk("R8 later accept clears", pend, 0);
      flush_low();
   endtask

   task automatic t_ready_idle();
      ready = 1'b1;
      tick(3);
      chk("R9 ready while idle", pend, 0);
      trig[3] = 1'b1;
      tick(3);
      chk("R9 edge after idle ready", pend, 4'b1000);
      chk("R3 cmd trig3 offered", cmd, 4);
      tick(1);
      chk("R5 taken at once", pend, 0);
      ready = 1'b0;
      flush_low();
   endtask

   initial begin
      tick(2);
      t_reset();
      t_single();
      t_multi();
      t_merge();
      t_clear();
      t_edge_wins();
      t_ready_idle();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule